// File: doc/BRIEF.md
# Out-of-Order Issue Queue with Tag Wakeup and Oldest-First Select

This block holds renamed operations until their operands become available and then hands them to execution units. Each slot keeps a destination tag, a unit class, and two source tags with one ready flag per source. Completing units drive result tags onto a broadcast bus. Every waiting source tag is compared against every broadcast tag, and a match sets that source's ready flag.

Selection works on the registered ready flags. It runs separately for each unit class. Among the slots whose two sources are both ready, it takes the one that was allocated earliest, and only when a unit of that class is free in the cycle. Younger operations that are ready may therefore leave ahead of older ones that are still waiting. A slot is released at the clock edge that ends the cycle in which it issues. One squash input empties the whole queue.

Top module: `issue_queue`

## Requirements
- R1: An operation is written into a free slot when `alloc_valid` is high, `alloc_ready` is high and `flush` is low. `alloc_ready` is low exactly when all DEPTH slots hold operations. An allocation offered while `alloc_ready` is low leaves no trace: that operation never issues.
- R2: Each source enters with the ready flag given by `alloc_src0_rdy` / `alloc_src1_rdy`. An operation with both flags set can issue in the cycle after its allocation.
- R3: At a clock edge, a broadcast port whose `bcast_valid` bit is high and whose tag (port p occupies bits p*6 +: 6 of `bcast_tag`) equals a waiting source tag sets that source's ready flag. The two sources of a slot wake independently, and one broadcast can wake both.
- R4: A tag broadcast in the same cycle that an operation is allocated also sets the ready flag of a matching source of that operation.
- R5: No operation issues before both of its ready flags are set. An operation whose last source wakes at edge t issues no earlier than the cycle that follows edge t.
- R6: Issue port c (`issue_valid` bit c, `issue_dst_tag` bits c*6 +: 6) carries only operations allocated with `alloc_cls` = c. It fires only in a cycle where `fu_free` bit c is high.
- R7: When several operations of one class are eligible, the one allocated earliest issues.
- R8: An eligible operation issues even while older operations of its class are still waiting on tags.
- R9: An issued operation leaves the queue at the edge that ends its issue cycle. It never issues twice, and its slot can be allocated again from the next cycle.
- R10: When `flush` is high at an edge, every slot is emptied, and a pending allocation in that cycle is dropped.
- R11: After reset the queue is empty, `alloc_ready` is high and no issue port is valid.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| flush | input | 1 | Empty the whole queue at the next edge |
| alloc_valid | input | 1 | Allocation request from rename |
| alloc_cls | input | CLS_W | Unit class of the new operation |
| alloc_src0_tag | input | 6 | First source tag |
| alloc_src0_rdy | input | 1 | First source already available |
| alloc_src1_tag | input | 6 | Second source tag |
| alloc_src1_rdy | input | 1 | Second source already available |
| alloc_dst_tag | input | 6 | Destination tag of the new operation |
| alloc_ready | output | 1 | At least one slot is free |
| bcast_valid | input | NUM_BCAST | One valid bit per result broadcast port |
| bcast_tag | input | NUM_BCAST*6 | Broadcast result tags, port p at bits p*6 +: 6 |
| fu_free | input | NUM_CLS | One bit per unit class: a unit of that class can accept an operation |
| issue_valid | output | NUM_CLS | Issue port c carries an operation |
| issue_dst_tag | output | NUM_CLS*6 | Destination tag on issue port c, at bits c*6 +: 6 |

## Verification
The checker watches the following on every clock cycle:
- no grant goes to a slot that lacks either ready flag;
- each class grants at most one slot;
- an issue port fires only when its class has a free unit;
- a granted slot is empty after the next edge;
- a squash empties the queue;
- occupancy grows by at most one per cycle.

Oldest-first order, the late-bypass case, the capture of a broadcast in the allocation cycle, and the silent refusal of an allocation into a full queue are not visible as single-cycle properties. The bench's scenarios show them by checking which destination tag leaves on which cycle.

// File: rtl/iq_pkg.sv
package iq_pkg;
  localparam int unsigned IQ_TAG_W = 6;

  typedef logic [IQ_TAG_W-1:0] iq_tag_t;

  typedef struct packed {
    iq_tag_t tag;
    logic    rdy;
  } iq_src_t;
endpackage

// File: rtl/iq_entry.sv
module iq_entry
  import iq_pkg::*;
#(
  parameter int unsigned CLS_W     = 1,
  parameter int unsigned NUM_BCAST = 2
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 flush,
  input  logic                                 wr_en,
  input  logic [CLS_W-1:0]                     wr_cls,
  input  iq_src_t                              wr_src0,
  input  iq_src_t                              wr_src1,
  input  iq_tag_t                              wr_dst,
  input  logic [NUM_BCAST-1:0]                 bcast_valid,
  input  logic [NUM_BCAST-1:0][IQ_TAG_W-1:0]   bcast_tag,
  input  logic                                 clear,
  output logic                                 valid,
  output logic [CLS_W-1:0]                     cls,
  output iq_tag_t                              dst,
  output logic                                 rdy0,
  output logic                                 rdy1
);
  logic             valid_q, valid_d, valid_en;
  logic [CLS_W-1:0] cls_q;
  iq_tag_t          dst_q;
  iq_src_t          src0_q, src1_q;
  logic             rdy0_d, rdy1_d, rdy_en;
  logic             hit_q0, hit_q1, hit_w0, hit_w1;

  // wakeup: compare every broadcast port with stored and incoming tags
  always_comb begin
    hit_q0 = 1'b0;
    hit_q1 = 1'b0;
    hit_w0 = 1'b0;
    hit_w1 = 1'b0;
    for (int p = 0; p < int'(NUM_BCAST); p++) begin
      if (bcast_valid[p]) begin
        if (bcast_tag[p] == src0_q.tag)  hit_q0 = 1'b1;
        if (bcast_tag[p] == src1_q.tag)  hit_q1 = 1'b1;
        if (bcast_tag[p] == wr_src0.tag) hit_w0 = 1'b1;
        if (bcast_tag[p] == wr_src1.tag) hit_w1 = 1'b1;
      end
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (flush)      valid_d = 1'b0;
    else if (wr_en) valid_d = 1'b1;
    else if (clear) valid_d = 1'b0;
    valid_en = flush | wr_en | clear;

    rdy_en = wr_en | valid_q;
    if (wr_en) begin
      rdy0_d = wr_src0.rdy | hit_w0;
      rdy1_d = wr_src1.rdy | hit_w1;
    end else begin
      rdy0_d = src0_q.rdy | hit_q0;
      rdy1_d = src1_q.rdy | hit_q1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q    <= 1'b0;
      cls_q      <= '0;
      dst_q      <= '0;
      src0_q     <= '0;
      src1_q     <= '0;
    end else begin
      if (valid_en) valid_q <= valid_d;
      if (wr_en) begin
        cls_q      <= wr_cls;
        dst_q      <= wr_dst;
        src0_q.tag <= wr_src0.tag;
        src1_q.tag <= wr_src1.tag;
      end
      if (rdy_en) begin
        src0_q.rdy <= rdy0_d;
        src1_q.rdy <= rdy1_d;
      end
    end
  end

  assign valid = valid_q;
  assign cls   = cls_q;
  assign dst   = dst_q;
  assign rdy0  = src0_q.rdy;
  assign rdy1  = src1_q.rdy;
endmodule

// File: rtl/iq_age_matrix.sv
module iq_age_matrix #(
  parameter int unsigned DEPTH = 8
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         alloc_en,
  input  logic [DEPTH-1:0]             alloc_oh,
  input  logic [DEPTH-1:0]             valid,
  output logic [DEPTH-1:0][DEPTH-1:0]  older
);
  // older[i][j] set: slot i was allocated before slot j
  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_row
    for (genvar j = 0; j < int'(DEPTH); j++) begin : g_col
      if (i == j) begin : g_diag
        assign older[i][j] = 1'b0;
      end else begin : g_cell
        logic bit_q, bit_d, bit_en;
        always_comb begin
          bit_en = alloc_en & (alloc_oh[i] | alloc_oh[j]);
          bit_d  = alloc_oh[i] ? 1'b0 : valid[i];
        end
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n)      bit_q <= 1'b0;
          else if (bit_en) bit_q <= bit_d;
        end
        assign older[i][j] = bit_q;
      end
    end
  end
endmodule

// File: rtl/iq_select.sv
module iq_select #(
  parameter int unsigned DEPTH = 8
) (
  input  logic [DEPTH-1:0]             req,
  input  logic [DEPTH-1:0][DEPTH-1:0]  older,
  output logic [DEPTH-1:0]             grant
);
  always_comb begin
    for (int i = 0; i < int'(DEPTH); i++) begin
      logic beaten;
      beaten = 1'b0;
      for (int j = 0; j < int'(DEPTH); j++) begin
        if (req[j] && older[j][i]) beaten = 1'b1;
      end
      grant[i] = req[i] & ~beaten;
    end
  end
endmodule

// File: rtl/issue_queue.sv
module issue_queue
  import iq_pkg::*;
#(
  parameter int unsigned DEPTH     = 8,
  parameter int unsigned NUM_CLS   = 2,
  parameter int unsigned NUM_BCAST = 2,
  localparam int unsigned CLS_W    = (NUM_CLS > 1) ? $clog2(NUM_CLS) : 1,
  localparam int unsigned TAG_W    = IQ_TAG_W
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         flush,
  input  logic                         alloc_valid,
  input  logic [CLS_W-1:0]             alloc_cls,
  input  logic [TAG_W-1:0]             alloc_src0_tag,
  input  logic                         alloc_src0_rdy,
  input  logic [TAG_W-1:0]             alloc_src1_tag,
  input  logic                         alloc_src1_rdy,
  input  logic [TAG_W-1:0]             alloc_dst_tag,
  output logic                         alloc_ready,
  input  logic [NUM_BCAST-1:0]         bcast_valid,
  input  logic [NUM_BCAST*TAG_W-1:0]   bcast_tag,
  input  logic [NUM_CLS-1:0]           fu_free,
  output logic [NUM_CLS-1:0]           issue_valid,
  output logic [NUM_CLS*TAG_W-1:0]     issue_dst_tag
);
  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q, rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_n <= rst_meta_q;
    end
  end

  logic [DEPTH-1:0]                    valid_vec, rdy0_vec, rdy1_vec, clear_vec;
  logic [DEPTH-1:0]                    alloc_oh;
  logic [DEPTH-1:0][TAG_W-1:0]         dst_arr;
  logic [DEPTH-1:0][CLS_W-1:0]         cls_arr;
  logic [DEPTH-1:0][DEPTH-1:0]         older;
  logic [NUM_CLS-1:0][DEPTH-1:0]       grant;
  logic [NUM_BCAST-1:0][TAG_W-1:0]     bcast_arr;
  logic                                alloc_fire;
  iq_src_t                             wr_src0, wr_src1;

  assign bcast_arr   = bcast_tag;
  assign alloc_ready = ~&valid_vec;
  assign alloc_fire  = alloc_valid & alloc_ready & ~flush;
  assign wr_src0     = '{tag: alloc_src0_tag, rdy: alloc_src0_rdy};
  assign wr_src1     = '{tag: alloc_src1_tag, rdy: alloc_src1_rdy};

  // lowest free slot takes the new operation
  always_comb begin
    logic found;
    found    = 1'b0;
    alloc_oh = '0;
    for (int i = 0; i < int'(DEPTH); i++) begin
      if (!valid_vec[i] && !found) begin
        alloc_oh[i] = 1'b1;
        found       = 1'b1;
      end
    end
  end

  for (genvar i = 0; i < int'(DEPTH); i++) begin : g_slot
    iq_entry #(
      .CLS_W     (CLS_W),
      .NUM_BCAST (NUM_BCAST)
    ) u_entry (
      .clk         (clk),
      .rst_n       (rst_sync_n),
      .flush       (flush),
      .wr_en       (alloc_fire & alloc_oh[i]),
      .wr_cls      (alloc_cls),
      .wr_src0     (wr_src0),
      .wr_src1     (wr_src1),
      .wr_dst      (alloc_dst_tag),
      .bcast_valid (bcast_valid),
      .bcast_tag   (bcast_arr),
      .clear       (clear_vec[i]),
      .valid       (valid_vec[i]),
      .cls         (cls_arr[i]),
      .dst         (dst_arr[i]),
      .rdy0        (rdy0_vec[i]),
      .rdy1        (rdy1_vec[i])
    );
  end

  iq_age_matrix #(.DEPTH(DEPTH)) u_age (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .alloc_en (alloc_fire),
    .alloc_oh (alloc_oh),
    .valid    (valid_vec),
    .older    (older)
  );

  for (genvar c = 0; c < int'(NUM_CLS); c++) begin : g_cls
    logic [DEPTH-1:0] req;
    always_comb begin
      for (int i = 0; i < int'(DEPTH); i++) begin
        req[i] = valid_vec[i] & rdy0_vec[i] & rdy1_vec[i]
               & (cls_arr[i] == CLS_W'(c)) & fu_free[c];
      end
    end

    iq_select #(.DEPTH(DEPTH)) u_sel (
      .req   (req),
      .older (older),
      .grant (grant[c])
    );

    always_comb begin
      logic [TAG_W-1:0] tag_mux;
      tag_mux = '0;
      for (int i = 0; i < int'(DEPTH); i++) begin
        tag_mux = tag_mux | ({TAG_W{grant[c][i]}} & dst_arr[i]);
      end
      issue_valid[c]                 = |grant[c];
      issue_dst_tag[c*TAG_W +: TAG_W] = tag_mux;
    end
  end

  always_comb begin
    clear_vec = '0;
    for (int c = 0; c < int'(NUM_CLS); c++) clear_vec = clear_vec | grant[c];
  end
endmodule

// File: rtl/iq_checker.sv
module iq_checker #(
  parameter int unsigned DEPTH   = 8,
  parameter int unsigned NUM_CLS = 2
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         flush,
  input logic [NUM_CLS-1:0]           fu_free,
  input logic [NUM_CLS-1:0]           issue_valid,
  input logic [DEPTH-1:0]             valid,
  input logic [DEPTH-1:0]             rdy0,
  input logic [DEPTH-1:0]             rdy1,
  input logic [NUM_CLS-1:0][DEPTH-1:0] grant
);
  logic [DEPTH-1:0] grant_any;
  always_comb begin
    grant_any = '0;
    for (int c = 0; c < int'(NUM_CLS); c++) grant_any = grant_any | grant[c];
  end

  for (genvar c = 0; c < int'(NUM_CLS); c++) begin : g_cls
    p_fu_gate_r6: assert property (@(posedge clk) disable iff (!rst_n)
      issue_valid[c] |-> fu_free[c]);

    p_grant_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (grant[c] & ~(valid & rdy0 & rdy1)) == '0);

    p_single_grant_r7: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant[c]));
  end

  p_issued_freed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (grant_any != '0) |=> ((valid & $past(grant_any)) == '0));

  p_flush_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid == '0));

  p_one_alloc_r1: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ($countones(valid) <= $countones($past(valid)) + 1));
endmodule

bind issue_queue iq_checker #(.DEPTH(DEPTH), .NUM_CLS(NUM_CLS)) u_iq_chk (
  .clk         (clk),
  .rst_n       (rst_sync_n),
  .flush       (flush),
  .fu_free     (fu_free),
  .issue_valid (issue_valid),
  .valid       (valid_vec),
  .rdy0        (rdy0_vec),
  .rdy1        (rdy1_vec),
  .grant       (grant)
);

// File: tb/issue_queue_bench.sv
module issue_queue_bench;
  localparam int DEPTH = 8;
  localparam int NCLS  = 2;
  localparam int NBC   = 2;
  localparam int NVEC  = 17;

  logic        clk;
  logic        rst_n;
  logic        flush;
  logic        alloc_valid;
  logic [0:0]  alloc_cls;
  logic [5:0]  alloc_src0_tag, alloc_src1_tag, alloc_dst_tag;
  logic        alloc_src0_rdy, alloc_src1_rdy;
  logic        alloc_ready;
  logic [1:0]  bcast_valid;
  logic [11:0] bcast_tag;
  logic [1:0]  fu_free;
  logic [1:0]  issue_valid;
  logic [11:0] issue_dst_tag;

  issue_queue #(.DEPTH(DEPTH), .NUM_CLS(NCLS), .NUM_BCAST(NBC)) u_issue_queue (
    .clk(clk), .rst_n(rst_n), .flush(flush),
    .alloc_valid(alloc_valid), .alloc_cls(alloc_cls),
    .alloc_src0_tag(alloc_src0_tag), .alloc_src0_rdy(alloc_src0_rdy),
    .alloc_src1_tag(alloc_src1_tag), .alloc_src1_rdy(alloc_src1_rdy),
    .alloc_dst_tag(alloc_dst_tag), .alloc_ready(alloc_ready),
    .bcast_valid(bcast_valid), .bcast_tag(bcast_tag),
    .fu_free(fu_free), .issue_valid(issue_valid), .issue_dst_tag(issue_dst_tag)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  typedef struct packed {
    logic       av;
    logic       cls;
    logic [5:0] s0;
    logic       r0;
    logic [5:0] s1;
    logic       r1;
    logic [5:0] dst;
    logic [1:0] bv;
    logic [5:0] bt0;
    logic [5:0] bt1;
    logic [1:0] fu;
    logic [1:0] ev;
    logic [5:0] ed0;
    logic [5:0] ed1;
  } vec_t;

  localparam vec_t VECS [0:NVEC-1] = '{
    // 0 R1: op A cls0 waits on tags 1 and 2, dst 10
    '{1'b1,1'b0,6'd1,1'b0,6'd2,1'b0,6'd10,2'b00,6'd0,6'd0,2'b11,2'b00,6'd0,6'd0},
    // 1 R3: op B ready at entry, dst 11; tag 1 wakes A src0 only
    '{1'b1,1'b0,6'd3,1'b1,6'd4,1'b1,6'd11,2'b01,6'd1,6'd0,2'b11,2'b00,6'd0,6'd0},
    // 2 R2: B issues; op C cls1 allocated while tag 5 broadcast
    '{1'b1,1'b1,6'd5,1'b0,6'd6,1'b1,6'd12,2'b10,6'd0,6'd5,2'b11,2'b01,6'd11,6'd0},
    // 3 R4: C caught the same-cycle broadcast; A still waits
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b00,6'd0,6'd0,2'b11,2'b10,6'd0,6'd12},
    // 4 R3: tag 2 wakes A src1
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b01,6'd2,6'd0,2'b11,2'b00,6'd0,6'd0},
    // 5 R6: A ready but no free unit; op D cls0 ready, dst 13
    '{1'b1,1'b0,6'd7,1'b1,6'd8,1'b1,6'd13,2'b00,6'd0,6'd0,2'b00,2'b00,6'd0,6'd0},
    // 6 R7: A older than D wins
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b00,6'd0,6'd0,2'b01,2'b01,6'd10,6'd0},
    // 7 R9: A gone, D follows
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b00,6'd0,6'd0,2'b01,2'b01,6'd13,6'd0},
    // 8 R9: queue drained, nothing repeats
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b00,6'd0,6'd0,2'b11,2'b00,6'd0,6'd0},
    // 9 R1: op E cls0 waits on tag 20, dst 14
    '{1'b1,1'b0,6'd20,1'b0,6'd21,1'b1,6'd14,2'b00,6'd0,6'd0,2'b11,2'b00,6'd0,6'd0},
    // 10 R5: op F ready, dst 15; E not eligible
    '{1'b1,1'b0,6'd22,1'b1,6'd23,1'b1,6'd15,2'b00,6'd0,6'd0,2'b11,2'b00,6'd0,6'd0},
    // 11 R8: younger F passes waiting E
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b00,6'd0,6'd0,2'b11,2'b01,6'd15,6'd0},
    // 12 R5: tag 20 on port 1, E not yet out
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b10,6'd0,6'd20,2'b11,2'b00,6'd0,6'd0},
    // 13 R8: E issues
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b00,6'd0,6'd0,2'b11,2'b01,6'd14,6'd0},
    // 14 R1: op G cls1, both sources on tag 30, dst 16
    '{1'b1,1'b1,6'd30,1'b0,6'd30,1'b0,6'd16,2'b00,6'd0,6'd0,2'b11,2'b00,6'd0,6'd0},
    // 15 R3: tag 30 wakes both sources, tag 31 unrelated
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b11,6'd30,6'd31,2'b11,2'b00,6'd0,6'd0},
    // 16 R6: G on class-1 port
    '{1'b0,1'b0,6'd0,1'b0,6'd0,1'b0,6'd0,2'b00,6'd0,6'd0,2'b11,2'b10,6'd0,6'd16}
  };

  function automatic string step_req(input int k);
    case (k)
      0, 9, 14:   return "R1";
      2:          return "R2";
      1, 4, 15:   return "R3";
      3:          return "R4";
      10, 12:     return "R5";
      5, 16:      return "R6";
      6:          return "R7";
      11, 13:     return "R8";
      default:    return "R9";
    endcase
  endfunction

  int  checks = 0;
  int  errors = 0;
  bit  done   = 1'b0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic report();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  task automatic idle();
    flush = 1'b0; alloc_valid = 1'b0; alloc_cls = '0;
    alloc_src0_tag = '0; alloc_src0_rdy = 1'b0;
    alloc_src1_tag = '0; alloc_src1_rdy = 1'b0;
    alloc_dst_tag = '0; bcast_valid = '0; bcast_tag = '0; fu_free = '0;
  endtask

  task automatic expect_issue(input string req, input logic [1:0] ev,
                              input logic [5:0] ed0, input logic [5:0] ed1);
    chk(issue_valid == ev, req, int'(issue_valid), int'(ev));
    if (ev[0]) chk(issue_dst_tag[5:0] == ed0, req, int'(issue_dst_tag[5:0]), int'(ed0));
    if (ev[1]) chk(issue_dst_tag[11:6] == ed1, req, int'(issue_dst_tag[11:6]), int'(ed1));
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      report();
    end
  end

  initial begin
    idle();
    rst_n = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1;
    // R11: empty after reset
    chk(issue_valid == 2'b00, "R11", int'(issue_valid), 0);
    chk(alloc_ready == 1'b1, "R11", int'(alloc_ready), 1);

    for (int k = 0; k < NVEC; k++) begin
      @(negedge clk);
      alloc_valid    = VECS[k].av;
      alloc_cls      = VECS[k].cls;
      alloc_src0_tag = VECS[k].s0;
      alloc_src0_rdy = VECS[k].r0;
      alloc_src1_tag = VECS[k].s1;
      alloc_src1_rdy = VECS[k].r1;
      alloc_dst_tag  = VECS[k].dst;
      bcast_valid    = VECS[k].bv;
      bcast_tag      = {VECS[k].bt1, VECS[k].bt0};
      fu_free        = VECS[k].fu;
      #1;
      expect_issue(step_req(k), VECS[k].ev, VECS[k].ed0, VECS[k].ed1);
    end

    // R1: fill every slot with ops waiting on tag 50
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      idle();
      alloc_valid = 1'b1; alloc_src0_tag = 6'd50; alloc_src1_tag = 6'd51;
      alloc_src1_rdy = 1'b1; alloc_dst_tag = 6'(32 + k);
    end
    @(negedge clk);
    idle();
    #1;
    chk(alloc_ready == 1'b0, "R1", int'(alloc_ready), 0);
    // R1: offer a ready op into the full queue; it must be dropped
    alloc_valid = 1'b1; alloc_src0_rdy = 1'b1; alloc_src1_rdy = 1'b1;
    alloc_dst_tag = 6'd63;
    @(negedge clk);
    idle();
    bcast_valid = 2'b01; bcast_tag = {6'd0, 6'd50};
    for (int k = 0; k < DEPTH; k++) begin
      @(negedge clk);
      idle();
      fu_free = 2'b01;
      #1;
      // R7: allocation order survives across all slots
      expect_issue("R7", 2'b01, 6'(32 + k), 6'd0);
      if (k == 1) chk(alloc_ready == 1'b1, "R9", int'(alloc_ready), 1);
    end
    @(negedge clk);
    fu_free = 2'b11;
    #1;
    // R1: the refused op never shows up
    expect_issue("R1", 2'b00, 6'd0, 6'd0);

    // R10: squash removes a ready op before it can issue
    @(negedge clk);
    idle();
    alloc_valid = 1'b1; alloc_cls = 1'b1; alloc_src0_rdy = 1'b1;
    alloc_src1_rdy = 1'b1; alloc_dst_tag = 6'd42;
    @(negedge clk);
    idle();
    flush = 1'b1;
    @(negedge clk);
    idle();
    fu_free = 2'b11;
    #1;
    expect_issue("R10", 2'b00, 6'd0, 6'd0);
    chk(alloc_ready == 1'b1, "R10", int'(alloc_ready), 1);

    // R10: allocation in a squash cycle is dropped
    @(negedge clk);
    idle();
    flush = 1'b1; alloc_valid = 1'b1; alloc_src0_rdy = 1'b1;
    alloc_src1_rdy = 1'b1; alloc_dst_tag = 6'd43;
    @(negedge clk);
    idle();
    fu_free = 2'b11;
    #1;
    expect_issue("R10", 2'b00, 6'd0, 6'd0);

    @(negedge clk);
    report();
  end
endmodule